// File: doc/BRIEF.md
# Multi-Channel Microsecond Countdown Timer

This block holds a bank of identical countdown channels. All channels share one clock and one external tick strobe, which pulses once per microsecond. Software arms a channel with a single write. That write sets the enable, selects one-shot or auto-reload operation, and gives a 29-bit terminal value N. The armed channel counts down once for each tick and expires after N+1 ticks. Each time it expires, it raises a level-high interrupt that stays high until software acknowledges it.

A one-shot channel disarms itself on expiry. A periodic channel reloads its terminal value on the expiring tick, so no tick is lost. Each channel has a load register and a status register. The status register returns the remaining count and the pending flag, and a write to it with the acknowledge bit set clears the flag. Writes take effect on the next clock edge. Reads are combinational on a separate read address.

Top module: `tickTimerBank`

## Requirements
- R1: After reset every channel is disarmed with count, terminal value and pending flag at zero, so every readback is 0 and every interrupt bit is low.
- R2: A write to a channel's load register sets the enable from bit 31, the auto-reload mode from bit 30, and both the terminal value and the current count from bits [28:0], starting at the next clock edge. The load register reads back {enable, mode, 0, terminal value}. The status register reads back {0, pending, 0, remaining count}.
- R3: The count of an enabled channel changes only on clock edges where the tick strobe is high. A disabled channel never changes its count.
- R4: A terminal value of N expires on the (N+1)th tick after the load. A value of 0 expires on the first tick, and the largest value, 0x1FFFFFFF, is accepted unchanged.
- R5: When a one-shot channel expires, it clears its enable, keeps a count of 0, and ignores later ticks.
- R6: When an auto-reload channel expires, it loads its terminal value on that same tick, so its expiries recur every N+1 ticks.
- R7: Each expiry sets the channel's pending flag, and interrupt bit i is high exactly while channel i's flag is set.
- R8: A status write with bit 30 set clears the pending flag. A status write with bit 30 clear has no effect. If an expiry occurs in the same cycle as a clear, the flag stays set.
- R9: A load write of all zeros stops the channel, leaving its count at 0, and does not change the pending flag.
- R10: If a load write and an expiry occur in the same cycle, the new load values are taken and the pending flag is still set.
- R11: Channel i's load register is at byte address 0x50*(i/2) + 8*(i%2), and its status register is 4 bytes above that. Writes to any other address change nothing, and reads of any other address return 0.
- R12: Channels are independent: a write or expiry on one channel leaves every other channel's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickStrobe | input | 1 | One-cycle pulse per microsecond tick |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write byte address |
| wrData | input | 32 | Write data |
| rdAddr | input | ADDR_W | Read byte address |
| rdData | output | 32 | Combinational read data |
| irq | output | NUM_CH | Level-high expiry interrupt per channel |

## Verification
A wrong count is visible on the status readback of the same cycle. It then shows up again on irq, one tick early or late, at the next expiry. A stale enable or mode bit is visible at once in the load readback. In a periodic channel it shows up one interval later, as a missing or extra interrupt. A pending flag that is dropped or set twice shows on irq in the cycle after the edge at which it went wrong. For this reason, the bench compares every register and every interrupt bit with a model after every clock edge.

// File: rtl/tickTimerPkg.sv
package tickTimerPkg;
  localparam int CNT_W   = 29;
  localparam int DATA_W  = 32;
  localparam int EN_BIT  = 31;
  localparam int PER_BIT = 30;
  localparam int ACK_BIT = 30;

  typedef struct packed {
    logic doLoad;
    logic doClear;
    logic doExpire;
    logic doDecrement;
    logic doReload;
    logic doStop;
  } chanStrobes_t;

  function automatic int unsigned chanBase(input int unsigned idx);
    return (idx / 2) * 32'h50 + (idx % 2) * 32'h8;
  endfunction
endpackage

// File: rtl/tickTimerCtrl.sv
module tickTimerCtrl
  import tickTimerPkg::*;
(
  input  logic         loadHit,
  input  logic         clearHit,
  input  logic         ackBit,
  input  logic         tickStrobe,
  input  logic         chanEn,
  input  logic         chanPeriodic,
  input  logic         countZero,
  output chanStrobes_t strobes
);
  logic liveTick;

  always_comb begin
    liveTick            = tickStrobe && chanEn;
    strobes.doLoad      = loadHit;
    strobes.doClear     = clearHit && ackBit;
    strobes.doExpire    = liveTick && countZero;
    strobes.doDecrement = liveTick && !countZero && !loadHit;
    strobes.doReload    = liveTick && countZero && chanPeriodic && !loadHit;
    strobes.doStop      = liveTick && countZero && !chanPeriodic && !loadHit;
  end
endmodule

// File: rtl/tickTimerData.sv
module tickTimerData
  import tickTimerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobes_t     strobes,
  input  logic             loadEn,
  input  logic             loadPer,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reloadVal,
  output logic             chanEn,
  output logic             chanPeriodic,
  output logic             pending
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count        <= '0;
      reloadVal    <= '0;
      chanEn       <= 1'b0;
      chanPeriodic <= 1'b0;
    end else if (strobes.doLoad) begin
      count        <= loadVal;
      reloadVal    <= loadVal;
      chanEn       <= loadEn;
      chanPeriodic <= loadPer;
    end else if (strobes.doReload) begin
      count <= reloadVal;
    end else if (strobes.doStop) begin
      chanEn <= 1'b0;
    end else if (strobes.doDecrement) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 pending <= 1'b0;
    else if (strobes.doExpire) pending <= 1'b1;
    else if (strobes.doClear)  pending <= 1'b0;
  end

  // R5: a one-shot stop leaves the count parked at zero
  a_r5_stop_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doStop |=> (count == '0) && !chanEn);
endmodule

// File: rtl/tickTimerBank.sv
module tickTimerBank
  import tickTimerPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickStrobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] irq
);
  localparam int STAT_OFS = 4;

  logic [NUM_CH-1:0]      loadHit, clearHit, chEn, chPer, chPend;
  logic [CNT_W-1:0]       chCount  [NUM_CH];
  logic [CNT_W-1:0]       chReload [NUM_CH];
  logic [DATA_W-1:0]      loadWord [NUM_CH];
  logic [DATA_W-1:0]      statWord [NUM_CH];
  logic                   unusedWrBits;

  assign unusedWrBits = wrData[29];

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    localparam logic [ADDR_W-1:0] LOAD_ADDR = ADDR_W'(chanBase(i));
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(chanBase(i) + STAT_OFS);

    chanStrobes_t strobes;

    assign loadHit[i]  = wrEn && (wrAddr == LOAD_ADDR);
    assign clearHit[i] = wrEn && (wrAddr == STAT_ADDR);

    tickTimerCtrl uCtrl (
      .loadHit     (loadHit[i]),
      .clearHit    (clearHit[i]),
      .ackBit      (wrData[ACK_BIT]),
      .tickStrobe  (tickStrobe),
      .chanEn      (chEn[i]),
      .chanPeriodic(chPer[i]),
      .countZero   (chCount[i] == '0),
      .strobes     (strobes)
    );

    tickTimerData uData (
      .clk         (clk),
      .rstN        (rstN),
      .strobes     (strobes),
      .loadEn      (wrData[EN_BIT]),
      .loadPer     (wrData[PER_BIT]),
      .loadVal     (wrData[CNT_W-1:0]),
      .count       (chCount[i]),
      .reloadVal   (chReload[i]),
      .chanEn      (chEn[i]),
      .chanPeriodic(chPer[i]),
      .pending     (chPend[i])
    );

    assign loadWord[i] = {chEn[i], chPer[i], 1'b0, chReload[i]};
    assign statWord[i] = {1'b0, chPend[i], 1'b0, chCount[i]};
    assign irq[i]      = chPend[i];

    // R3: no tick and no load means the count holds
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!tickStrobe && !loadHit[i]) |=> $stable(chCount[i]));

    // R6: an auto-reload expiry restores the terminal value
    a_r6_reload: assert property (@(posedge clk) disable iff (!rstN)
      (tickStrobe && chEn[i] && chPer[i] && chCount[i] == '0 && !loadHit[i])
      |=> chCount[i] == $past(chReload[i]));

    // R7: the flag only rises after a live tick at zero
    a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chPend[i]) |-> $past(tickStrobe && chEn[i] && chCount[i] == '0));

    // R8: an acknowledge with no competing expiry drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
      (clearHit[i] && wrData[ACK_BIT] && !(tickStrobe && chEn[i] && chCount[i] == '0))
      |=> !chPend[i]);

    // R10: a load colliding with expiry takes the new value and keeps the flag
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rstN)
      (loadHit[i] && tickStrobe && chEn[i] && chCount[i] == '0)
      |=> chPend[i] && chCount[i] == $past(wrData[CNT_W-1:0]));
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rdAddr == ADDR_W'(chanBase(i)))            rdData = loadWord[i];
      if (rdAddr == ADDR_W'(chanBase(i) + STAT_OFS)) rdData = statWord[i];
    end
  end
endmodule

// File: tb/tickTimerBank_test.sv
`timescale 1ns/100ps
module tickTimerBank_test;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickStrobe = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [NCH-1:0] irq;

  tickTimerBank #(.NUM_CH(NCH), .ADDR_W(8)) uut (
    .clk(clk), .rstN(rstN), .tickStrobe(tickStrobe), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  always #2 clk = ~clk;

  bit        mEn  [NCH];
  bit        mPer [NCH];
  bit [28:0] mRel [NCH];
  bit [28:0] mCnt [NCH];
  bit        mPend[NCH];

  int    nChecks = 0, nFail = 0;
  string curReq = "R1";
  bit    doneFlag = 0;

  function automatic bit [7:0] baseOf(input int ch);
    return 8'(80 * (ch / 2) + 8 * (ch % 2));
  endfunction

  function automatic bit [31:0] expLoad(input int ch);
    return {mEn[ch], mPer[ch], 1'b0, mRel[ch]};
  endfunction

  function automatic bit [31:0] expStat(input int ch);
    return {1'b0, mPend[ch], 1'b0, mCnt[ch]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic modelStep(input bit tk, input bit we, input bit [7:0] wa, input bit [31:0] wd);
    for (int ch = 0; ch < NCH; ch++) begin
      bit expire, ld, clr;
      expire = tk && mEn[ch] && mCnt[ch] == 0;
      ld  = we && wa == baseOf(ch);
      clr = we && wa == baseOf(ch) + 8'd4 && wd[30];
      if (ld) begin
        mEn[ch] = wd[31]; mPer[ch] = wd[30]; mRel[ch] = wd[28:0]; mCnt[ch] = wd[28:0];
      end else if (tk && mEn[ch]) begin
        if (mCnt[ch] == 0) begin
          if (mPer[ch]) mCnt[ch] = mRel[ch];
          else          mEn[ch] = 1'b0;
        end else mCnt[ch] = mCnt[ch] - 1;
      end
      if (expire)   mPend[ch] = 1'b1;
      else if (clr) mPend[ch] = 1'b0;
    end
  endtask

  task automatic checkAll();
    logic [NCH-1:0] expIrq;
    for (int ch = 0; ch < NCH; ch++) expIrq[ch] = mPend[ch];
    chk(curReq, "irq", 32'(irq), 32'(expIrq));
    for (int ch = 0; ch < NCH; ch++) begin
      rdAddr = baseOf(ch);        #0.1;
      chk(curReq, $sformatf("load ch%0d", ch), rdData, expLoad(ch));
      rdAddr = baseOf(ch) + 8'd4; #0.1;
      chk(curReq, $sformatf("status ch%0d", ch), rdData, expStat(ch));
    end
    rdAddr = 8'h30; #0.1;
    chk(curReq, "unmapped read", rdData, 32'h0);
  endtask

  // one clock: inputs set before the edge, model updated at the edge, checked after
  task automatic cyc(input bit tk, input bit we, input bit [7:0] wa, input bit [31:0] wd);
    tickStrobe = tk; wrEn = we; wrAddr = wa; wrData = wd;
    @(posedge clk);
    modelStep(tk, we, wa, wd);
    @(negedge clk);
    tickStrobe = 1'b0; wrEn = 1'b0;
    checkAll();
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    checkAll();

    curReq = "R2";
    cyc(0, 1, baseOf(0), 32'h8000_0005);
    cyc(0, 1, baseOf(1), 32'hC000_0003);

    curReq = "R3";
    repeat (4) cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);

    curReq = "R4";
    cyc(0, 1, baseOf(2), 32'h8000_0000);
    cyc(1, 0, 0, 0);
    chk("R4", "zero value first tick irq", 32'(irq[2]), 32'h1);
    cyc(0, 1, baseOf(3), 32'h9FFF_FFFF);
    rdAddr = baseOf(3) + 8'd4; #0.1;
    chk("R4", "max count", rdData, 32'h1FFF_FFFF);
    cyc(0, 1, baseOf(3), 32'h0);

    curReq = "R8";
    cyc(0, 1, baseOf(2) + 8'd4, 32'h0);
    cyc(0, 1, baseOf(2) + 8'd4, 32'h4000_0000);
    chk("R8", "ack clears", 32'(irq[2]), 32'h0);

    curReq = "R5";
    cyc(0, 1, baseOf(2), 32'h8000_0002);
    repeat (2) cyc(1, 0, 0, 0);
    chk("R5", "not yet", 32'(irq[2]), 32'h0);
    cyc(1, 0, 0, 0);
    chk("R5", "third tick", 32'(irq[2]), 32'h1);
    repeat (3) cyc(1, 0, 0, 0);

    curReq = "R6";
    cyc(0, 1, baseOf(2), 32'hC000_0002);
    repeat (9) cyc(1, 0, 0, 0);

    curReq = "R8";
    cyc(0, 1, baseOf(2), 32'hC000_0000);
    cyc(1, 1, baseOf(2) + 8'd4, 32'h4000_0000);
    chk("R8", "expiry beats clear", 32'(irq[2]), 32'h1);

    curReq = "R9";
    cyc(0, 1, baseOf(2), 32'h0);
    repeat (3) cyc(1, 0, 0, 0);

    curReq = "R10";
    cyc(0, 1, baseOf(1), 32'h8000_0000);
    cyc(0, 1, baseOf(1) + 8'd4, 32'h4000_0000);
    cyc(1, 1, baseOf(1), 32'h8000_0007);
    chk("R10", "flag kept", 32'(irq[1]), 32'h1);

    curReq = "R11";
    cyc(0, 1, 8'h10, 32'hC000_0001);
    cyc(0, 1, 8'h20, 32'h4000_0000);
    cyc(1, 1, 8'h60, 32'h8000_0003);

    curReq = "R12";
    for (int n = 0; n < 4000; n++) begin
      bit tk; bit [2:0] op; int ch; bit [31:0] wd; bit [7:0] wa;
      tk = 1'($urandom % 2);
      op = 3'($urandom % 6);
      ch = int'($urandom % NCH);
      wd = 32'h0; wa = 8'h0;
      case (op)
        3'd0: begin
          wa = baseOf(ch);
          wd = {1'($urandom % 4 != 0), 1'($urandom % 2), 1'b0, 29'($urandom % 6)};
          if ($urandom % 50 == 0) wd[28:0] = 29'h1FFF_FFFF;
        end
        3'd1: begin wa = baseOf(ch) + 8'd4; wd = $urandom; end
        3'd2: begin wa = 8'($urandom); wd = $urandom; end
        default: ;
      endcase
      cyc(tk, op <= 3'd2, wa, wd);
    end

    finishRun();
  end
endmodule